// File: doc/BRIEF.md
# Maskable Interrupt Control Unit

This block collects interrupt requests for an embedded processor core. It handles sixteen maskable sources and one non-maskable source. Twelve sources come from on-chip peripherals that are already synchronous to the core clock. The other four come from general-purpose external pins. Every maskable source has an enable bit and a pending bit. Each external pin has a two-bit trigger selection that chooses high level, low level, rising edge or falling edge.

The pending bit of a level-triggered source follows its input. The pending bit of an edge-triggered source is set when the edge is seen, and it stays set until software writes a one to its clear bit. Among the sources that are both enabled and pending, the one with the lowest number wins. The unit drives a request line and the 4-bit number of that winning source.

The non-maskable input is synchronised and edge-detected like the external pins. Its request stays latched until the core acknowledges it. No enable bit affects it.

Top module: `irq_unit`

## Requirements
- R1: After reset, `enable_o` and `pending_o` are all zero, every external trigger field is 00 (high level), and both `irq_o` and `nmi_o` are low.
- R2: A cycle with `en_we_i` high loads `en_wdata_i` into the enable register, and `enable_o` shows the new value after that clock edge.
- R3: A peripheral source n (n < 12, driven on `per_irq_i[n]`) is level-triggered. Its pending bit equals the value `per_irq_i[n]` had at the previous clock edge, and `pend_clr_i` has no effect on it.
- R4: External pin k (`ext_pin_i[k]`, k = 0..3) maps to source 12+k. It passes through two synchroniser flops, so a pin change sampled at one clock edge first affects the pending bit at the second edge after it.
- R5: A trigger field (bits [2k+1:2k] of the mode register) of 00 makes pending follow the synchronised pin. A field of 01 makes pending follow the inverse of the synchronised pin.
- R6: A trigger field of 10 sets pending on a 0-to-1 change of the synchronised pin. A field of 11 sets pending on a 1-to-0 change. Once set, the bit stays set until a cycle with `pend_clr_i[12+k]` high clears it. If a new edge arrives in that same cycle, the bit stays set.
- R7: Writing a one to the clear bit of a source in a level mode (00 or 01) does not change its pending bit while its input still holds the active level.
- R8: A source is recorded as pending whether or not it is enabled. A pending source that is not enabled never raises `irq_o`.
- R9: `irq_o` is high exactly when some source is both enabled and pending. While it is high, `irq_vec_o` holds the lowest-numbered such source.
- R10: A 0-to-1 change of the synchronised `nmi_pin_i` sets `nmi_o`. `nmi_o` stays set until a cycle with `nmi_ack_i` high clears it, unless a new edge arrives in that same cycle. The enable register has no effect on `nmi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| per_irq_i | input | 12 | Level request lines from on-chip peripherals (sources 0..11) |
| ext_pin_i | input | 4 | Asynchronous external interrupt pins (sources 12..15) |
| nmi_pin_i | input | 1 | Asynchronous non-maskable interrupt pin |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 16 | New enable value |
| mode_we_i | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata_i | input | 8 | Two trigger bits per external pin |
| pend_clr_i | input | 16 | Write-one-to-clear for edge-latched pending bits |
| nmi_ack_i | input | 1 | Acknowledge that clears the non-maskable request |
| enable_o | output | 16 | Current enable register |
| pending_o | output | 16 | Current pending register |
| irq_o | output | 1 | Maskable interrupt request to the core |
| irq_vec_o | output | 4 | Index of the winning source |
| nmi_o | output | 1 | Latched non-maskable request |

## Verification
The bench uses the default parameters: sixteen sources, four external pins, and the external group placed at sources 12 to 15. With these values every vector value from 0 to 15 is reachable. The priority encoder's choice crosses the boundary between peripheral and pin sources, and all four trigger codes are used on real pins. Random changes to the mode register reach mode switches while an edge-latched bit is still set. Random clear and acknowledge pulses reach the cycles in which a clear or an acknowledge coincides with a fresh edge.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
        logic [WIDTH-1:0] last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_i;
        sync_d.stage2 = sync_q.stage1;
        sync_d.last   = sync_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign lvl_o  = sync_q.stage2;
    assign prev_o = sync_q.last;

    // R4: the value seen by the detectors is the pin two edges earlier
    a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lvl_o == $past(sync_q.stage1));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_unit_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_EXT  = 4,
    parameter int EXT_BASE = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     int_lvl_i,
    input  logic [NUM_EXT-1:0]     ext_lvl_i,
    input  logic [NUM_EXT-1:0]     ext_prev_i,
    input  logic                   en_we_i,
    input  logic [NUM_SRC-1:0]     en_wdata_i,
    input  logic                   mode_we_i,
    input  logic [2*NUM_EXT-1:0]   mode_wdata_i,
    input  logic [NUM_SRC-1:0]     pend_clr_i,
    output logic [NUM_SRC-1:0]     enable_o,
    output logic [NUM_SRC-1:0]     pending_o
);

    localparam int EXT_LAST = EXT_BASE + NUM_EXT;

    typedef struct packed {
        logic [NUM_SRC-1:0]   en;
        logic [NUM_SRC-1:0]   pend;
        logic [2*NUM_EXT-1:0] mode;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (en_we_i) begin
            regs_d.en = en_wdata_i;
        end
        if (mode_we_i) begin
            regs_d.mode = mode_wdata_i;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i >= EXT_BASE && i < EXT_LAST) begin
                int e;
                logic rise, fall, held;
                e    = i - EXT_BASE;
                rise = ext_lvl_i[e] & ~ext_prev_i[e];
                fall = ~ext_lvl_i[e] & ext_prev_i[e];
                held = regs_q.pend[i] & ~pend_clr_i[i];
                case (trig_e'(regs_q.mode[2*e +: 2]))
                    TRIG_HIGH: regs_d.pend[i] = ext_lvl_i[e];
                    TRIG_LOW:  regs_d.pend[i] = ~ext_lvl_i[e];
                    TRIG_RISE: regs_d.pend[i] = rise | held;
                    default:   regs_d.pend[i] = fall | held;
                endcase
            end else begin
                regs_d.pend[i] = int_lvl_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign enable_o  = regs_q.en;
    assign pending_o = regs_q.pend;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        if (g >= EXT_BASE && g < EXT_LAST) begin : g_ext
            // R6: an edge-latched bit only drops through a clear
            a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (regs_q.mode[2*(g-EXT_BASE)+1] && regs_q.pend[g]
                 && !pend_clr_i[g] && !mode_we_i) |=> regs_q.pend[g]);
        end else begin : g_int
            // R3: peripheral lines are copied one edge later
            a_r3_int_follow: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> regs_q.pend[g] == $past(int_lvl_i[g]));
        end
    end

    // R2: a write strobe lands in the enable register
    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> enable_o == $past(en_wdata_i));

endmodule

// File: rtl/irq_nmi.sv
module irq_nmi (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic prev_i,
    input  logic ack_i,
    output logic nmi_o
);

    typedef struct packed {
        logic req;
    } nmi_t;

    nmi_t nmi_d, nmi_q;

    always_comb begin
        nmi_d     = nmi_q;
        nmi_d.req = (lvl_i & ~prev_i) | (nmi_q.req & ~ack_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q <= '0;
        end else begin
            nmi_q <= nmi_d;
        end
    end

    assign nmi_o = nmi_q.req;

    // R10: latched until acknowledged
    a_r10_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_o && !ack_i) |=> nmi_o);

    // R10: a synchronised rising edge always raises the request
    a_r10_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i && !prev_i) |=> nmi_o);

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] active_i,
    output logic               req_o,
    output logic [IDX_W-1:0]   vec_o
);

    localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

    always_comb begin
        req_o = 1'b0;
        vec_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                req_o = 1'b1;
                vec_o = IDX_W'(i);
            end
        end
    end

    // R9: the reported source is really active
    a_r9_vec_active: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> active_i[vec_o]);

    // R9: no active source sits below the reported one
    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> ((active_i & ((ONE << vec_o) - ONE)) == '0));

endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
    parameter int  NUM_SRC  = 16,
    parameter int  NUM_EXT  = 4,
    parameter int  EXT_BASE = 12,
    localparam int NUM_INT  = NUM_SRC - NUM_EXT,
    localparam int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_INT-1:0]   per_irq_i,
    input  logic [NUM_EXT-1:0]   ext_pin_i,
    input  logic                 nmi_pin_i,
    input  logic                 en_we_i,
    input  logic [NUM_SRC-1:0]   en_wdata_i,
    input  logic                 mode_we_i,
    input  logic [2*NUM_EXT-1:0] mode_wdata_i,
    input  logic [NUM_SRC-1:0]   pend_clr_i,
    input  logic                 nmi_ack_i,
    output logic [NUM_SRC-1:0]   enable_o,
    output logic [NUM_SRC-1:0]   pending_o,
    output logic                 irq_o,
    output logic [IDX_W-1:0]     irq_vec_o,
    output logic                 nmi_o
);

    logic [NUM_EXT:0]   sync_lvl, sync_prev;
    logic [NUM_SRC-1:0] int_lvl;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_map
        if (g < EXT_BASE) begin : g_low
            assign int_lvl[g] = per_irq_i[g];
        end else if (g >= EXT_BASE + NUM_EXT) begin : g_high
            assign int_lvl[g] = per_irq_i[g-NUM_EXT];
        end else begin : g_pin
            assign int_lvl[g] = 1'b0;
        end
    end

    irq_sync #(.WIDTH(NUM_EXT + 1)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({nmi_pin_i, ext_pin_i}),
        .lvl_o   (sync_lvl),
        .prev_o  (sync_prev)
    );

    irq_regs #(
        .NUM_SRC  (NUM_SRC),
        .NUM_EXT  (NUM_EXT),
        .EXT_BASE (EXT_BASE)
    ) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .int_lvl_i    (int_lvl),
        .ext_lvl_i    (sync_lvl[NUM_EXT-1:0]),
        .ext_prev_i   (sync_prev[NUM_EXT-1:0]),
        .en_we_i      (en_we_i),
        .en_wdata_i   (en_wdata_i),
        .mode_we_i    (mode_we_i),
        .mode_wdata_i (mode_wdata_i),
        .pend_clr_i   (pend_clr_i),
        .enable_o     (enable_o),
        .pending_o    (pending_o)
    );

    irq_nmi i_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_lvl[NUM_EXT]),
        .prev_i (sync_prev[NUM_EXT]),
        .ack_i  (nmi_ack_i),
        .nmi_o  (nmi_o)
    );

    irq_prio #(.NUM_SRC(NUM_SRC)) i_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (pending_o & enable_o),
        .req_o    (irq_o),
        .vec_o    (irq_vec_o)
    );

    // R8: a disabled source can never be the one presented
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> enable_o[irq_vec_o]);

endmodule

// File: tb/test_irq_unit.sv
module test_irq_unit;

    localparam int NS = 16;
    localparam int NE = 4;
    localparam int EB = 12;
    localparam int NI = NS - NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] per_irq = '0;
    logic [NE-1:0] ext_pin = '0;
    logic          nmi_pin = 1'b0;
    logic          en_we = 1'b0;
    logic [NS-1:0] en_wdata = '0;
    logic          mode_we = 1'b0;
    logic [2*NE-1:0] mode_wdata = '0;
    logic [NS-1:0] pend_clr = '0;
    logic          nmi_ack = 1'b0;
    logic [NS-1:0] enable_o, pending_o;
    logic          irq_o, nmi_o;
    logic [3:0]    irq_vec_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_unit i_irq_unit (
        .clk(clk), .rst_n(rst_n), .per_irq_i(per_irq), .ext_pin_i(ext_pin),
        .nmi_pin_i(nmi_pin), .en_we_i(en_we), .en_wdata_i(en_wdata),
        .mode_we_i(mode_we), .mode_wdata_i(mode_wdata), .pend_clr_i(pend_clr),
        .nmi_ack_i(nmi_ack), .enable_o(enable_o), .pending_o(pending_o),
        .irq_o(irq_o), .irq_vec_o(irq_vec_o), .nmi_o(nmi_o)
    );

    // Reference state, advanced from the requirements at each rising edge
    logic [NE:0]     m_s1, m_s2, m_s3;
    logic [NS-1:0]   m_en, m_pend;
    logic [2*NE-1:0] m_mode;
    logic            m_nmi;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
            m_en = '0; m_pend = '0; m_mode = '0; m_nmi = 1'b0;
        end else begin
            logic [NS-1:0] np;
            for (int i = 0; i < NS; i++) begin
                if (i >= EB && i < EB + NE) begin
                    int k;
                    logic hold;
                    k = i - EB;
                    hold = m_pend[i] & ~pend_clr[i];
                    case (m_mode[2*k +: 2])
                        2'b00: np[i] = m_s2[k];
                        2'b01: np[i] = ~m_s2[k];
                        2'b10: np[i] = (m_s2[k] & ~m_s3[k]) | hold;
                        default: np[i] = (~m_s2[k] & m_s3[k]) | hold;
                    endcase
                end else begin
                    np[i] = per_irq[i];
                end
            end
            m_pend = np;
            m_nmi  = (m_s2[NE] & ~m_s3[NE]) | (m_nmi & ~nmi_ack);
            if (en_we)   m_en   = en_wdata;
            if (mode_we) m_mode = mode_wdata;
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = {nmi_pin, ext_pin};
        end
    end

    function automatic logic [4:0] exp_prio(input logic [NS-1:0] act);
        for (int i = 0; i < NS; i++) begin
            if (act[i]) return {1'b1, 4'(i)};
        end
        return 5'd0;
    endfunction

    function automatic string pend_tag(input int i);
        if (i < EB) return "R3";
        if (m_mode[2*(i-EB)+1]) return "R6";
        return "R5";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [4:0] p;
        chk("R2 enable", 32'(enable_o), 32'(m_en));
        for (int i = 0; i < NS; i++) begin
            chk(pend_tag(i), 32'(pending_o[i]), 32'(m_pend[i]));
        end
        p = exp_prio(m_pend & m_en);
        chk("R9 irq", 32'(irq_o), 32'(p[4]));
        if (p[4]) chk("R9 vector", 32'(irq_vec_o), 32'(p[3:0]));
        chk("R10 nmi", 32'(nmi_o), 32'(m_nmi));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        pend_clr = '0;
        nmi_ack  = 1'b0;
        en_we    = 1'b0;
        mode_we  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 enable", 32'(enable_o), 0);
        chk("R1 pending", 32'(pending_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 nmi", 32'(nmi_o), 0);
        rst_n = 1'b1;
        cyc();

        // R1: default mode is high level, so a pin going high sets pending
        // R4: two synchroniser stages before the detector
        en_we = 1'b1; en_wdata = 16'hFFFF;
        cyc();
        ext_pin[1] = 1'b1;
        cyc();
        chk("R4 after edge 1", 32'(pending_o[13]), 0);
        cyc();
        chk("R4 after edge 2", 32'(pending_o[13]), 0);
        cyc();
        chk("R4 after edge 3", 32'(pending_o[13]), 1);
        chk("R1 default mode high level", 32'(pending_o[13]), 1);

        // R7: clearing a level source is ignored while active
        per_irq[0] = 1'b1;
        cyc();
        pend_clr = 16'h2001;
        cyc();
        chk("R7 level clr internal", 32'(pending_o[0]), 1);
        chk("R7 level clr pin", 32'(pending_o[13]), 1);
        chk("R9 lowest vector", 32'(irq_vec_o), 0);

        // R8: disabled pending source raises no request
        en_we = 1'b1; en_wdata = 16'h0000;
        cyc();
        chk("R8 pending kept", 32'(pending_o[0]), 1);
        chk("R8 no irq", 32'(irq_o), 0);

        // R6: rising edge on pin 2 latches, clear drops it
        per_irq[0] = 1'b0; ext_pin = '0;
        mode_we = 1'b1; mode_wdata = 8'b00_10_00_00;
        en_we = 1'b1; en_wdata = 16'h4000;
        repeat (4) cyc();
        ext_pin[2] = 1'b1;
        repeat (3) cyc();
        chk("R6 rise latched", 32'(pending_o[14]), 1);
        ext_pin[2] = 1'b0;
        repeat (4) cyc();
        chk("R6 held after pin low", 32'(pending_o[14]), 1);
        chk("R9 vector 14", 32'(irq_vec_o), 14);
        pend_clr[14] = 1'b1;
        cyc();
        chk("R6 cleared", 32'(pending_o[14]), 0);

        // R10: NMI with all enables off
        en_we = 1'b1; en_wdata = 16'h0000;
        nmi_pin = 1'b1;
        repeat (3) cyc();
        chk("R10 nmi set", 32'(nmi_o), 1);
        nmi_pin = 1'b0;
        repeat (3) cyc();
        chk("R10 nmi held", 32'(nmi_o), 1);
        nmi_ack = 1'b1;
        cyc();
        chk("R10 nmi acked", 32'(nmi_o), 0);

        // Random phase, compared against the reference every cycle
        void'($urandom(32'd1234));
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(3) == 0) per_irq = NI'($urandom);
            if ($urandom_range(2) == 0) ext_pin = ext_pin ^ NE'(1 << $urandom_range(NE-1));
            if ($urandom_range(9) == 0) nmi_pin = ~nmi_pin;
            if ($urandom_range(15) == 0) begin en_we = 1'b1; en_wdata = NS'($urandom); end
            if ($urandom_range(40) == 0) begin mode_we = 1'b1; mode_wdata = 8'($urandom); end
            if ($urandom_range(4) == 0) pend_clr = NS'($urandom);
            if ($urandom_range(5) == 0) nmi_ack = 1'b1;
            cyc();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule